// File: doc/BRIEF.md
# Version Frame Time Lookup

This block turns a virtual-time value into the index of the version frame whose interval covers that time. Each frame slot holds the virtual time at which its version was created. Within one object these creation times rise strictly with the slot index. A query time T therefore falls in frame i when the stamp of i is at or below T and the stamp of the next enabled frame is above T. This is the exact frame at T when one exists. Otherwise it is the newest older frame.

Every slot has its own magnitude comparator. The compare results, gated by an enable mask, drive a priority encoder that picks the highest qualifying slot. The caller builds the mask from its oldest and current frame pointers. It gets back the index, a hit flag, an exact-match flag, and a below-range flag. The below-range flag means T is older than every enabled frame, so the caller must fall back to its archive copy.

With more than one object, each slot becomes a small memory indexed by object number. All slot memories are read in parallel, and that read adds one pipeline stage. Times compare as plain unsigned numbers. A floating-point time can be used if its exponent sits in the upper bits.

Top module: `vtt_lookup`

## Requirements
- R1: A result appears with `r_valid` high exactly LAT cycles after `q_valid` is sampled high. LAT is 2 when OBJS > 1 and 1 when OBJS = 1. Back-to-back queries give back-to-back results, and `r_valid` is low in every other cycle.
- R2: `r_index` is the highest enabled slot whose stamp is less than or equal to `q_time`, so its stamp is at or below T and the next enabled stamp is above T.
- R3: `r_exact` is 1 only when the selected slot's stamp equals `q_time`. `r_exact` implies `r_hit`.
- R4: When `q_mask` is nonzero and `q_time` is below every enabled stamp, the result is `r_below` = 1, `r_hit` = 0, `r_exact` = 0 and `r_index` = 0.
- R5: When `q_mask` is all zero, the result is `r_hit`, `r_exact` and `r_below` all 0, with `r_index` = 0.
- R6: A slot whose `q_mask` bit (bit i for slot i) is 0 never takes part in the selection, whatever its stamp.
- R7: Stamps are kept per object number. A write to one object leaves the lookups of every other object unchanged.
- R8: Comparison is unsigned over all TIME_W bits, so 16'h8000 ranks above 16'h7FFF.
- R9: While `rst_n` is low and right after reset, `r_valid`, `r_hit`, `r_exact`, `r_below` and `r_index` are all 0.
- R10: With `wr_en` high, `wr_time` is stored as the stamp of slot `wr_frame` for object `wr_obj`. A query issued in any later cycle sees the new stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Stamp write strobe |
| wr_obj | input | OBJ_W | Object number for the write |
| wr_frame | input | IDX_W | Frame slot for the write |
| wr_time | input | TIME_W | Creation time stored in the slot |
| q_valid | input | 1 | Query strobe |
| q_obj | input | OBJ_W | Object number of the query |
| q_time | input | TIME_W | Virtual time to translate |
| q_mask | input | FRAMES | Enabled slots, bit i for slot i |
| r_valid | output | 1 | Result strobe |
| r_index | output | IDX_W | Covering frame index |
| r_hit | output | 1 | Some enabled stamp is at or below the query time |
| r_exact | output | 1 | Selected stamp equals the query time |
| r_below | output | 1 | Query is older than every enabled slot |

## Verification
A wrong stamp in a slot shows up only when a query lands near that slot's boundary. It then appears as an index off by one, or as an exact flag that is wrong. It shows at the ports LAT cycles after the query that touches it. The vectors are therefore placed on both sides of each boundary and exactly on it. A fault in the object memories or in the stage-one registers shows as results that belong to another object, or results that arrive in the wrong cycle. Per-object queries and a back-to-back query pair expose these on the first result affected.

// File: rtl/vtt_pkg.sv
package vtt_pkg;
   // Flags carried from the compare stage to the result register.
   typedef struct packed {
      logic hit;
      logic exact;
      logic below;
   } vtt_flags_t;
endpackage

// File: rtl/vtt_stamp_store.sv
module vtt_stamp_store #(
   parameter int TIME_W = 16,
   parameter int FRAMES = 8,
   parameter int OBJS   = 4,
   parameter int OBJ_W  = 2,
   parameter int IDX_W  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [OBJ_W-1:0]               wr_obj,
   input  logic [IDX_W-1:0]               wr_frame,
   input  logic [TIME_W-1:0]              wr_time,
   input  logic [OBJ_W-1:0]               rd_obj,
   output logic [FRAMES-1:0][TIME_W-1:0]  stamps
);
   for (genvar f = 0; f < FRAMES; f++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_frame == IDX_W'(f));
      if (OBJS == 1) begin : g_reg
         // Single object: one plain register per slot, readable at once.
         logic [TIME_W-1:0] stamp_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       stamp_q <= '0;
            else if (sel && wr_obj == '0)     stamp_q <= wr_time;
         end
         assign stamps[f] = stamp_q;
         logic unused_rd;
         assign unused_rd = ^rd_obj;
      end else begin : g_ram
         // Several objects: a small memory per slot, read with a register.
         logic [TIME_W-1:0] mem [OBJS];
         logic [TIME_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (sel) mem[wr_obj] <= wr_time;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mem[rd_obj];
         end
         assign stamps[f] = rd_q;
      end
   end
endmodule

// File: rtl/vtt_cmp_row.sv
module vtt_cmp_row #(
   parameter int TIME_W = 16,
   parameter int FRAMES = 8
) (
   input  logic [FRAMES-1:0][TIME_W-1:0] stamps,
   input  logic [TIME_W-1:0]             t,
   output logic [FRAMES-1:0]             le,
   output logic [FRAMES-1:0]             eq
);
   // Unsigned magnitude compare per slot.
   for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
      assign le[f] = (stamps[f] <= t);
      assign eq[f] = (stamps[f] == t);
   end
endmodule

// File: rtl/vtt_prio_enc.sv
module vtt_prio_enc #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   // The highest set bit wins. Stamps rise with the index, so this is the
   // newest qualifying frame.
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vtt_lookup.sv
module vtt_lookup #(
   parameter int TIME_W = 16,
   parameter int FRAMES = 8,
   parameter int OBJS   = 4,
   parameter int OBJ_W  = (OBJS > 1) ? $clog2(OBJS) : 1,
   parameter int IDX_W  = $clog2(FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OBJ_W-1:0]  wr_obj,
   input  logic [IDX_W-1:0]  wr_frame,
   input  logic [TIME_W-1:0] wr_time,
   input  logic              q_valid,
   input  logic [OBJ_W-1:0]  q_obj,
   input  logic [TIME_W-1:0] q_time,
   input  logic [FRAMES-1:0] q_mask,
   output logic              r_valid,
   output logic [IDX_W-1:0]  r_index,
   output logic              r_hit,
   output logic              r_exact,
   output logic              r_below
);
   import vtt_pkg::*;

   localparam bit MULTI = (OBJS > 1);

   if (FRAMES < 2) begin : g_bad_frames
      $error("vtt_lookup: FRAMES must be at least 2");
   end
   if (TIME_W < 1) begin : g_bad_width
      $error("vtt_lookup: TIME_W must be positive");
   end
   if (IDX_W < $clog2(FRAMES)) begin : g_bad_idx
      $error("vtt_lookup: IDX_W too small for FRAMES");
   end

   logic [FRAMES-1:0][TIME_W-1:0] stamps;

   vtt_stamp_store #(
      .TIME_W(TIME_W), .FRAMES(FRAMES), .OBJS(OBJS),
      .OBJ_W(OBJ_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_obj(wr_obj), .wr_frame(wr_frame), .wr_time(wr_time),
      .rd_obj(q_obj), .stamps(stamps)
   );

   // Query fields aligned with the stamps seen by the comparators.
   logic              s_valid;
   logic [TIME_W-1:0] s_time;
   logic [FRAMES-1:0] s_mask;

   if (MULTI) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_valid <= 1'b0;
            s_time  <= '0;
            s_mask  <= '0;
         end else begin
            s_valid <= q_valid;
            s_time  <= q_time;
            s_mask  <= q_mask;
         end
      end
   end else begin : g_direct
      assign s_valid = q_valid;
      assign s_time  = q_time;
      assign s_mask  = q_mask;
   end

   logic [FRAMES-1:0] le, eq;

   vtt_cmp_row #(.TIME_W(TIME_W), .FRAMES(FRAMES)) u_cmp (
      .stamps(stamps), .t(s_time), .le(le), .eq(eq)
   );

   logic [IDX_W-1:0] sel_idx;
   logic             sel_any;

   vtt_prio_enc #(.N(FRAMES), .IDX_W(IDX_W)) u_enc (
      .req(le & s_mask), .idx(sel_idx), .any(sel_any)
   );

   vtt_flags_t flags_c;
   always_comb begin
      flags_c.hit   = sel_any;
      flags_c.exact = sel_any && eq[sel_idx];
      flags_c.below = (|s_mask) && !sel_any;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_index <= '0;
         r_hit   <= 1'b0;
         r_exact <= 1'b0;
         r_below <= 1'b0;
      end else begin
         r_valid <= s_valid;
         if (s_valid) begin
            r_index <= sel_any ? sel_idx : '0;
            r_hit   <= flags_c.hit;
            r_exact <= flags_c.exact;
            r_below <= flags_c.below;
         end
      end
   end
endmodule

// File: rtl/vtt_lookup_chk.sv
module vtt_lookup_chk #(
   parameter int TIME_W = 16,
   parameter int FRAMES = 8,
   parameter int OBJS   = 4,
   parameter int OBJ_W  = 2,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [OBJ_W-1:0]  wr_obj,
   input logic [IDX_W-1:0]  wr_frame,
   input logic [TIME_W-1:0] wr_time,
   input logic              q_valid,
   input logic [OBJ_W-1:0]  q_obj,
   input logic [TIME_W-1:0] q_time,
   input logic [FRAMES-1:0] q_mask,
   input logic              r_valid,
   input logic [IDX_W-1:0]  r_index,
   input logic              r_hit,
   input logic              r_exact,
   input logic              r_below
);
   localparam int LAT = (OBJS > 1) ? 2 : 1;

   // Independent delay model of the query strobe and of "mask nonzero".
   logic [LAT-1:0] vpipe, mpipe;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpipe <= '0;
         mpipe <= '0;
      end else begin
         vpipe <= {vpipe[LAT-1:0], q_valid} >> 0;
         mpipe <= {mpipe[LAT-1:0], |q_mask} >> 0;
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid == vpipe[LAT-1]);

   p_exact_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_exact) |-> r_hit);

   p_below_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> !(r_hit && r_below));

   p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !r_hit) |-> (r_index == '0 && !r_exact));

   p_empty_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && !mpipe[LAT-1]) |-> (!r_hit && !r_below));
endmodule

bind vtt_lookup vtt_lookup_chk #(
   .TIME_W(TIME_W), .FRAMES(FRAMES), .OBJS(OBJS),
   .OBJ_W(OBJ_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_vtt_lookup.sv
module tb_vtt_lookup;
   localparam int TIME_W = 16;
   localparam int FRAMES = 8;
   localparam int OBJS   = 4;
   localparam int OBJ_W  = 2;
   localparam int IDX_W  = 3;
   localparam int NV     = 17;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [OBJ_W-1:0]  wr_obj = '0;
   logic [IDX_W-1:0]  wr_frame = '0;
   logic [TIME_W-1:0] wr_time = '0;
   logic              q_valid = 1'b0;
   logic [OBJ_W-1:0]  q_obj = '0;
   logic [TIME_W-1:0] q_time = '0;
   logic [FRAMES-1:0] q_mask = '0;
   logic              r_valid;
   logic [IDX_W-1:0]  r_index;
   logic              r_hit, r_exact, r_below;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   vtt_lookup #(.TIME_W(TIME_W), .FRAMES(FRAMES), .OBJS(OBJS)) dut (.*);

   // {obj, time, mask, exp_index, exp_hit, exp_exact, exp_below}
   localparam logic [31:0] VEC [NV] = '{
      {2'd0, 16'd35,    8'hFF, 3'd2, 1'b1, 1'b0, 1'b0}, // R2 inside interval
      {2'd0, 16'd40,    8'hFF, 3'd3, 1'b1, 1'b1, 1'b0}, // R3 exact
      {2'd0, 16'd5,     8'hFF, 3'd0, 1'b0, 1'b0, 1'b1}, // R4 below
      {2'd0, 16'd10,    8'hFF, 3'd0, 1'b1, 1'b1, 1'b0}, // R3 first slot
      {2'd0, 16'd999,   8'hFF, 3'd7, 1'b1, 1'b0, 1'b0}, // R2 past last
      {2'd0, 16'd80,    8'hFF, 3'd7, 1'b1, 1'b1, 1'b0}, // R3 last slot
      {2'd0, 16'd55,    8'h0F, 3'd3, 1'b1, 1'b0, 1'b0}, // R6 upper disabled
      {2'd0, 16'd25,    8'hFC, 3'd0, 1'b0, 1'b0, 1'b1}, // R6 lower disabled
      {2'd0, 16'd35,    8'h00, 3'd0, 1'b0, 1'b0, 1'b0}, // R5 empty mask
      {2'd1, 16'd35,    8'hFF, 3'd0, 1'b0, 1'b0, 1'b1}, // R7 other object
      {2'd1, 16'd1250,  8'hFF, 3'd2, 1'b1, 1'b0, 1'b0}, // R7
      {2'd1, 16'd1700,  8'hFF, 3'd7, 1'b1, 1'b1, 1'b0}, // R7
      {2'd2, 16'h8000,  8'h07, 3'd1, 1'b1, 1'b1, 1'b0}, // R8
      {2'd2, 16'h7FFF,  8'h07, 3'd0, 1'b1, 1'b1, 1'b0}, // R8
      {2'd2, 16'hBFFF,  8'h07, 3'd1, 1'b1, 1'b0, 1'b0}, // R8
      {2'd2, 16'hFFFF,  8'h07, 3'd2, 1'b1, 1'b0, 1'b0}, // R8
      {2'd2, 16'h0001,  8'h07, 3'd0, 1'b0, 1'b0, 1'b1}  // R8 / R4
   };

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic write_stamp(input int obj, input int fr, input int t);
      @(negedge clk);
      wr_en = 1'b1; wr_obj = OBJ_W'(obj); wr_frame = IDX_W'(fr);
      wr_time = TIME_W'(t);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input int obj, input int t, input int mask);
      @(negedge clk);
      q_valid = 1'b1; q_obj = OBJ_W'(obj); q_time = TIME_W'(t);
      q_mask = FRAMES'(mask);
   endtask

   task automatic expect_res(input string req, input int idx, input int hit,
                             input int ex, input int bel);
      check(req, int'(r_valid), 1);
      check(req, int'(r_index), idx);
      check(req, int'(r_hit), hit);
      check(req, int'(r_exact), ex);
      check(req, int'(r_below), bel);
   endtask

   // Single query; result checked two cycles after issue.
   task automatic run_one(input string req, input int obj, input int t,
                          input int mask, input int idx, input int hit,
                          input int ex, input int bel);
      issue(obj, t, mask);
      @(negedge clk);
      q_valid = 1'b0;
      check({req, " early"}, int'(r_valid), 0); // R1 not before LAT
      @(negedge clk);
      expect_res(req, idx, hit, ex, bel);
      @(negedge clk);
      check({req, " pulse"}, int'(r_valid), 0); // R1 single cycle
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 valid", int'(r_valid), 0);
      check("R9 index", int'(r_index), 0);
      check("R9 hit",   int'(r_hit), 0);
      check("R9 exact", int'(r_exact), 0);
      check("R9 below", int'(r_below), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after reset", int'(r_valid), 0);

      for (int f = 0; f < FRAMES; f++) begin
         write_stamp(0, f, 10 * (f + 1));
         write_stamp(1, f, 1000 + 100 * f);
      end
      write_stamp(2, 0, 16'h7FFF);
      write_stamp(2, 1, 16'h8000);
      write_stamp(2, 2, 16'hC000);

      for (int v = 0; v < NV; v++) begin
         run_one($sformatf("vec%0d", v), int'(VEC[v][31:30]),
                 int'(VEC[v][29:14]), int'(VEC[v][13:6]), int'(VEC[v][5:3]),
                 int'(VEC[v][2]), int'(VEC[v][1]), int'(VEC[v][0]));
      end

      // R10 overwrite slot 3 of object 0, then query around it
      write_stamp(0, 3, 45);
      run_one("R10 new stamp exact", 0, 45, 8'hFF, 3, 1, 1, 0);
      run_one("R10 below new stamp", 0, 42, 8'hFF, 2, 1, 0, 0);
      // R7 object 1 untouched by the object 0 write
      run_one("R7 isolation", 1, 1300, 8'hFF, 3, 1, 1, 0);

      // R1 back-to-back queries give back-to-back results
      issue(0, 35, 8'hFF);
      issue(1, 1250, 8'hFF);
      @(negedge clk);
      q_valid = 1'b0;
      expect_res("R1 b2b first", 2, 1, 0, 0);
      @(negedge clk);
      expect_res("R1 b2b second", 2, 1, 0, 0);
      @(negedge clk);
      check("R1 b2b end", int'(r_valid), 0);

      // R9 reset in mid-run clears the outputs
      issue(0, 80, 8'hFF);
      @(negedge clk);
      q_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 rerun valid", int'(r_valid), 0);
      check("R9 rerun hit", int'(r_hit), 0);
      check("R9 rerun index", int'(r_index), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule